// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

Three registers of `WIDTH` bits each take their next value from a single transfer bus. A 2-bit source select places one value on that bus: register 0, register 1, register 2, or an external data word. Each register has its own load enable, and the external word is how registers receive an initial value. On a clock edge, every register whose load enable is high captures the bus. Every other register keeps its value.

Because there is only one bus, all registers that load in a cycle receive the same word. One source can therefore be copied to several destinations in a single cycle. Two transfers from different sources cannot happen in the same cycle. Exchanging two registers needs a third register as temporary storage and takes three cycles.

The bus is brought out as a combinational output so the selected source can be observed.

Top module: `shared_bus_xfer`

## Requirements
- R1: While `rst_ni` is low, all three registers clear to zero asynchronously. They stay zero until a load occurs after reset is released.
- R2: Select codes 0, 1 and 2 (binary 00, 01, 10) place register 0, 1 and 2 on `bus_o`, combinationally and in the same cycle.
- R3: Select code 3 (binary 11) places `ext_data_i` on `bus_o`. This is how registers are initialised.
- R4: A register whose load bit is 1 at a rising clock edge shows the pre-edge `bus_o` value from that edge onward. Load bit k drives register k.
- R5: A register whose load bit is 0 at an edge keeps its value.
- R6: When several load bits are 1 in one cycle, every selected register receives the same bus value.
- R7: A register that loads while it is itself the selected source keeps its value.
- R8: Loads from different sources cannot occur in one cycle. With two registers loading while one of them is the source, the other receives the source's old value and the source stays unchanged. A swap through the third register completes in three cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Bus source: 0..2 register, 3 external word |
| load_i | input | 3 | Per-register load enable, bit k for register k |
| ext_data_i | input | WIDTH | External word for initialisation |
| bus_o | output | WIDTH | Current bus value |
| r0_o | output | WIDTH | Register 0 contents |
| r1_o | output | WIDTH | Register 1 contents |
| r2_o | output | WIDTH | Register 2 contents |

## Verification
The bus value depends combinationally on the select input and the register contents. The bench therefore checks `bus_o` one time step after it drives new inputs on the falling edge, within the same cycle. A loaded register shows the captured value one register stage later. The bench samples the register outputs one time step after the next rising edge and compares them with a model. That model holds the previous contents and is updated from the bus value present before the edge. Reset clearing is checked while reset is still held low, without waiting for any edge.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int unsigned NUM_REGS = 3;
  localparam int unsigned NUM_SRC  = NUM_REGS + 1;
  localparam int unsigned SEL_W    = $clog2(NUM_SRC);

  typedef enum logic [SEL_W-1:0] {
    SRC_R0  = 2'd0,
    SRC_R1  = 2'd1,
    SRC_R2  = 2'd2,
    SRC_EXT = 2'd3
  } bus_src_e;
endpackage

// File: rtl/xfer_bus_mux.sv
module xfer_bus_mux #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0][WIDTH-1:0] src_i,
  input  logic [SEL_W-1:0]              sel_i,
  output logic [WIDTH-1:0]              bus_o
);
  // AND-OR select: one-hot decode, then OR of gated sources
  logic [NUM_SRC-1:0] hot;
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) hot[i] = (sel_i == SEL_W'(i));
  end

  always_comb begin
    bus_o = '0;
    for (int i = 0; i < NUM_SRC; i++) bus_o |= src_i[i] & {WIDTH{hot[i]}};
  end
endmodule

// File: rtl/xfer_reg.sv
module xfer_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // free-running clock, load steers feedback
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/shared_bus_xfer.sv
module shared_bus_xfer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               sel_i,
  input  logic [2:0]               load_i,
  input  logic [WIDTH-1:0]         ext_data_i,
  output logic [WIDTH-1:0]         bus_o,
  output logic [WIDTH-1:0]         r0_o,
  output logic [WIDTH-1:0]         r1_o,
  output logic [WIDTH-1:0]         r2_o
);
  import xfer_pkg::*;

  logic [NUM_REGS-1:0][WIDTH-1:0] reg_q;
  logic [NUM_SRC-1:0][WIDTH-1:0]  src;
  logic [WIDTH-1:0]               bus;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    xfer_reg #(.WIDTH(WIDTH)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i[k]),
      .d_i    (bus),
      .q_o    (reg_q[k])
    );
    assign src[k] = reg_q[k];
  end
  assign src[SRC_EXT] = ext_data_i;

  xfer_bus_mux #(.WIDTH(WIDTH), .NUM_SRC(NUM_SRC)) u_mux (
    .src_i (src),
    .sel_i (sel_i),
    .bus_o (bus)
  );

  assign bus_o = bus;
  assign r0_o  = reg_q[0];
  assign r1_o  = reg_q[1];
  assign r2_o  = reg_q[2];
endmodule

// File: rtl/shared_bus_xfer_chk.sv
module shared_bus_xfer_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       sel_i,
  input logic [2:0]       load_i,
  input logic [WIDTH-1:0] ext_data_i,
  input logic [WIDTH-1:0] bus_o,
  input logic [WIDTH-1:0] r0_o,
  input logic [WIDTH-1:0] r1_o,
  input logic [WIDTH-1:0] r2_o
);
  a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (r0_o == '0 && r1_o == '0 && r2_o == '0));

  a_r2_bus_r0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 2'd0 |-> bus_o == r0_o);
  a_r2_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 2'd2 |-> bus_o == r2_o);
  a_r3_bus_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 2'd3 |-> bus_o == ext_data_i);

  a_r4_load_r0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i[0] |=> r0_o == $past(bus_o));
  a_r4_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i[1] |=> r1_o == $past(bus_o));
  a_r4_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i[2] |=> r2_o == $past(bus_o));

  a_r5_hold_r0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i[0] |=> $stable(r0_o));
  a_r5_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i[1] |=> $stable(r1_o));
  a_r5_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i[2] |=> $stable(r2_o));

  a_r6_broadcast_01: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i[0] && load_i[1]) |=> r0_o == r1_o);

  a_r7_self_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd1 && load_i[1]) |=> $stable(r1_o));
endmodule

bind shared_bus_xfer shared_bus_xfer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .load_i     (load_i),
  .ext_data_i (ext_data_i),
  .bus_o      (bus_o),
  .r0_o       (r0_o),
  .r1_o       (r1_o),
  .r2_o       (r2_o)
);

// File: tb/sim_shared_bus_xfer.sv
`timescale 1ns/1ps
module sim_shared_bus_xfer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   sel = 2'd0;
  logic [2:0]   load = 3'b000;
  logic [W-1:0] ext = '0;
  logic [W-1:0] bus, r0, r1, r2;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m [3];

  always #5 clk = ~clk;

  shared_bus_xfer #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .load_i(load),
    .ext_data_i(ext), .bus_o(bus), .r0_o(r0), .r1_o(r1), .r2_o(r2)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(req, r0, m[0]);
    chk(req, r1, m[1]);
    chk(req, r2, m[2]);
  endtask

  function automatic logic [W-1:0] bus_model(input logic [1:0] s, input logic [W-1:0] e);
    return (s == 2'd3) ? e : m[s];
  endfunction

  // drive at negedge, check bus in-cycle, clock, update model, check regs
  task automatic xfer(input string req, input logic [1:0] s, input logic [2:0] ld,
                      input logic [W-1:0] e);
    logic [W-1:0] b;
    @(negedge clk);
    sel = s; load = ld; ext = e;
    #1;
    b = bus_model(s, e);
    chk(req, bus, b);
    @(posedge clk);
    for (int k = 0; k < 3; k++) if (ld[k]) m[k] = b;
    #1;
    chk_regs(req);
    @(negedge clk);
    load = 3'b000;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) m[k] = '0;
    #1;
    chk_regs("R1 reset");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk_regs("R1 after release");
  endtask

  task automatic t_init();
    xfer("R3 R4 init r0", 2'd3, 3'b001, 8'hA5);
    xfer("R3 R4 init r1", 2'd3, 3'b010, 8'h3C);
    xfer("R3 R4 init r2", 2'd3, 3'b100, 8'h81);
  endtask

  task automatic t_bus_view();
    for (int s = 0; s < 3; s++) xfer("R2 bus source view", 2'(s), 3'b000, 8'hFF);
    xfer("R5 hold with ext on bus", 2'd3, 3'b000, 8'h00);
  endtask

  task automatic t_copy();
    xfer("R4 copy r2 to r0", 2'd2, 3'b001, 8'h11);
  endtask

  task automatic t_broadcast();
    xfer("R6 broadcast ext", 2'd3, 3'b111, 8'h5A);
    xfer("R3 R6 reload r0 r2", 2'd3, 3'b101, 8'hC3);
    xfer("R6 broadcast r0 to r1 r2", 2'd0, 3'b110, 8'h00);
  endtask

  task automatic t_self_load();
    xfer("R7 init r1", 2'd3, 3'b010, 8'h77);
    xfer("R7 self load r1", 2'd1, 3'b010, 8'hEE);
    xfer("R7 self load r1 with r0", 2'd1, 3'b011, 8'h22);
  endtask

  task automatic t_swap();
    xfer("R8 set r0", 2'd3, 3'b001, 8'h12);
    xfer("R8 set r1", 2'd3, 3'b010, 8'h34);
    // cross-load in one cycle: r1 gets r0, r0 stays
    xfer("R8 single source", 2'd0, 3'b011, 8'h00);
    chk("R8 no parallel swap r1", r1, 8'h12);
    chk("R8 no parallel swap r0", r0, 8'h12);
    xfer("R8 set r1 again", 2'd3, 3'b010, 8'h34);
    xfer("R8 swap step1", 2'd0, 3'b100, 8'h00);
    xfer("R8 swap step2", 2'd1, 3'b001, 8'h00);
    xfer("R8 swap step3", 2'd2, 3'b010, 8'h00);
    chk("R8 swapped r0", r0, 8'h34);
    chk("R8 swapped r1", r1, 8'h12);
  endtask

  task automatic t_async_reset();
    xfer("R1 preload", 2'd3, 3'b111, 8'h99);
    @(negedge clk); #2;
    rst_n = 1'b0;
    #1;
    for (int k = 0; k < 3; k++) m[k] = '0;
    chk_regs("R1 async clear");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk_regs("R1 zero after release");
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_bus_view();
    t_copy();
    t_broadcast();
    t_self_load();
    t_swap();
    t_async_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule